// File: doc/BRIEF.md
# EPROM Pulse-Verify Programming Sequencer

This block writes a byte image from a local buffer into an ultraviolet-erasable or one-time-programmable EPROM. It drives the device pins directly and switches the supply-select outputs that steer an external supply generator. Before any pulse it raises the program supply and moves the core supply to its programming level. It then works through the array one byte at a time. Each byte gets chip-enable program pulses of fixed width, and after each pulse the sequencer reads the byte back in verify mode. A byte that still reads wrong gets another pulse, up to a hard limit. A byte that verifies gets no further pulse. Image bytes that are all ones are skipped, because erased cells already read that way.

When every byte is programmed, the sequencer reads the whole array back at an upper check supply and then at a lower one. A mismatch at either level ends the run with a fail. A run that stops with a fail reports the failing address and the number of pulses that byte received. Every setup, hold, pulse and access interval is given in nanoseconds and turned into a clock-cycle count at elaboration, using the clock frequency parameter.

Top module: `eprom_burn_seq`

## Requirements
- R1: After reset, dev_e_n and dev_g_n are 1, dev_dq_oe, sup_prog, busy, done and fail are 0, and vcc_sel is 2'b00 (read level).
- R2: Before any program pulse, sup_prog is 1 and vcc_sel is 2'b01 (program level). The address, the output data, the data driver enable and both supply selects stay unchanged for at least SETUP_NS worth of cycles before dev_e_n falls.
- R3: Each program pulse holds dev_e_n low for exactly round(PULSE_NS*CLK_MHZ/1000) cycles, which is 100 µs at nominal settings.
- R4: After dev_e_n rises, the data stays driven and unchanged for at least the setup count. dev_g_n falls no earlier than twice the setup count after that rise. Verify is done with dev_e_n 1 and dev_g_n 0, and dev_dq_oe is never 1 while dev_g_n is 0.
- R5: The sequencer pulses a byte repeatedly until the verify read matches the image. It applies no further pulse after a match. Addresses are taken from 0 upward to the last address.
- R6: The pulse count for a byte starts at 0 and increments on every pulse. A byte that matches after exactly MAX_PULSES pulses passes. If the verify after pulse MAX_PULSES still mismatches, the run stops with fail 1, fail_addr set to that address and fail_pulses set to MAX_PULSES, and later addresses get no pulse.
- R7: An image byte of all ones receives no pulse.
- R8: After programming, every address is read with vcc_sel 2'b10 (upper check), then every address with vcc_sel 2'b11 (lower check). The first mismatch stops the run with fail 1, fail_addr set to that address and fail_pulses 0. Nothing further is read after that mismatch.
- R9: A run with no mismatch ends with done 1 and fail 0. done and fail are never 1 together. Whenever busy is 0, the pins are idle: dev_e_n 1, dev_g_n 1, dev_dq_oe 0, sup_prog 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency CLK_MHZ |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Last run completed without error |
| fail | output | 1 | Last run stopped on an error |
| fail_addr | output | ADDR_W | Address that caused the fail |
| fail_pulses | output | PCW | Pulses given to the failing byte (0 for a check-phase fail) |
| img_rd_addr | output | ADDR_W | Image buffer read address |
| img_rd_data | input | DATA_W | Image buffer data, valid one cycle after the address |
| dev_addr | output | ADDR_W | Device address pins |
| dev_dq_out | output | DATA_W | Data driven to the device |
| dev_dq_oe | output | 1 | Enable for the data driver |
| dev_dq_in | input | DATA_W | Data read from the device |
| dev_e_n | output | 1 | Device chip enable, active low, used as the program pulse |
| dev_g_n | output | 1 | Device output enable, active low |
| sup_prog | output | 1 | Select the high program supply |
| vcc_sel | output | 2 | Core supply level: 00 read, 01 program, 10 upper check, 11 lower check |

## Verification
The bench builds the sequencer with ADDR_W = 3 and CLK_MHZ = 1. That gives eight bytes, 100-cycle pulses and 2-cycle setup gaps, so a byte that needs exactly 25 pulses, a byte that needs 30 and both check passes all fit in a few thousand cycles. A behavioural device model in the bench counts pulses per address and applies the programmed zeros once a configurable pulse count is reached. It can also flip a bit at one chosen check level, which lets the bench place failures in the programming phase, the upper check pass and the lower check pass.

// File: rtl/burn_pkg.sv
// Package burn_pkg
// Shared types and elaboration helpers for the EPROM programming sequencer.
// Assumes: timing parameters are given in nanoseconds and the clock in MHz.
package burn_pkg;

    // Core supply level selector, as driven on vcc_sel.
    typedef enum logic [1:0] {
        VCC_READ   = 2'b00,
        VCC_PROG   = 2'b01,
        VCC_CHK_HI = 2'b10,
        VCC_CHK_LO = 2'b11
    } vcc_sel_t;

    // Sequencer states.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SUPPLY,
        ST_FETCH,
        ST_LATCH,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_GAP,
        ST_VERIFY,
        ST_RECOVER,
        ST_NEXT,
        ST_CK_SETTLE,
        ST_CK_FETCH,
        ST_CK_READ,
        ST_CK_REC
    } burn_state_t;

    // Minimum interval: round up to whole cycles, at least one.
    function automatic int cyc_ceil(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    // Nominal interval: round to nearest whole cycle, at least one.
    function automatic int cyc_round(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 500) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/burn_timer.sv
// Module burn_timer
// Loadable down-counter that times every interval of the sequencer.
// Assumes: the owner loads N-1 on entry to an N-cycle state and leaves the
// state in the cycle where zero is 1.
module burn_timer #(
    parameter int W    = 8,
    parameter int MAXV = 200
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    // Count down from the loaded value and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R3: the loaded interval never exceeds the longest computed interval.
    p_tmr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= W'(MAXV));

endmodule

// File: rtl/burn_pulse_ctr.sv
// Module burn_pulse_ctr
// Counts program pulses given to the current byte and flags the retry limit.
// Assumes: inc is never raised once at_limit is 1 (the sequencer stops first).
module burn_pulse_ctr #(
    parameter int MAX_PULSES = 25,
    parameter int W          = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         at_limit
);

    // Clear per byte and step once per pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (inc)
            count <= count + 1'b1;
    end

    assign at_limit = (count == W'(MAX_PULSES));

    // R6: the byte never receives a pulse past the limit.
    p_cnt_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= W'(MAX_PULSES));

endmodule

// File: rtl/burn_addr_gen.sv
// Module burn_addr_gen
// Array address counter shared by the programming and check passes.
// Assumes: the array spans the full 2**AW address range.
module burn_addr_gen #(
    parameter int AW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [AW-1:0] addr,
    output logic          is_last
);

    // Return to address 0 or step to the next address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (clr)
            addr <= '0;
        else if (adv)
            addr <= addr + 1'b1;
    end

    assign is_last = &addr;

    // R5: the sequencer never steps past the last address.
    p_addr_nowrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        adv |-> !is_last);

endmodule

// File: rtl/eprom_burn_seq.sv
// Module eprom_burn_seq
// Programs a byte image into an EPROM with repeated pulse-and-verify, then
// reads the whole array back at two check supply levels.
// Assumes: img_rd_data is valid one clock after img_rd_addr changes; the
// device data bus is split into dev_dq_out/dev_dq_oe/dev_dq_in at the pads;
// supply generation reacts to sup_prog/vcc_sel within SETUP_NS.
module eprom_burn_seq #(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int CLK_MHZ    = 50,
    parameter int PULSE_NS   = 100_000,
    parameter int SETUP_NS   = 2_000,
    parameter int TOE_NS     = 100,
    parameter int TDF_NS     = 130,
    parameter int MAX_PULSES = 25,
    localparam int PCW       = $clog2(MAX_PULSES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [PCW-1:0]    fail_pulses,
    output logic [ADDR_W-1:0] img_rd_addr,
    input  logic [DATA_W-1:0] img_rd_data,
    output logic [ADDR_W-1:0] dev_addr,
    output logic [DATA_W-1:0] dev_dq_out,
    output logic              dev_dq_oe,
    input  logic [DATA_W-1:0] dev_dq_in,
    output logic              dev_e_n,
    output logic              dev_g_n,
    output logic              sup_prog,
    output logic [1:0]        vcc_sel
);

    import burn_pkg::*;

    localparam int PULSE_CYC = cyc_round(PULSE_NS, CLK_MHZ);
    localparam int SETUP_CYC = cyc_ceil(SETUP_NS, CLK_MHZ);
    localparam int TOE_CYC   = cyc_ceil(TOE_NS, CLK_MHZ);
    localparam int TDF_CYC   = cyc_ceil(TDF_NS, CLK_MHZ);
    localparam int TMR_MAX   = imax(imax(PULSE_CYC, SETUP_CYC), imax(TOE_CYC, TDF_CYC));
    localparam int TW        = $clog2(TMR_MAX + 1);
    localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

    burn_state_t       state, nxt;
    logic              tmr_load, tmr_zero;
    logic [TW-1:0]     tmr_val;
    logic              addr_clr, addr_adv, addr_last;
    logic [ADDR_W-1:0] addr;
    logic              pc_clr, pc_inc, pc_limit;
    logic [PCW-1:0]    pc_count;
    logic [DATA_W-1:0] wr_byte;
    logic              wr_load, vfy_cap, vfy_ok;
    logic              ck_lo, ck_lo_set, ck_lo_clr;
    logic              fin_ok, fin_pgm_fail, fin_ck_fail;

    burn_timer #(.W(TW), .MAXV(TMR_MAX - 1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    burn_pulse_ctr #(.MAX_PULSES(MAX_PULSES), .W(PCW)) u_pulses (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pc_clr),
        .inc      (pc_inc),
        .count    (pc_count),
        .at_limit (pc_limit)
    );

    burn_addr_gen #(.AW(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (addr_clr),
        .adv     (addr_adv),
        .addr    (addr),
        .is_last (addr_last)
    );

    // Next-state, timer loads and datapath strobes.
    always_comb begin
        nxt          = state;
        tmr_load     = 1'b0;
        tmr_val      = '0;
        addr_clr     = 1'b0;
        addr_adv     = 1'b0;
        pc_clr       = 1'b0;
        pc_inc       = 1'b0;
        wr_load      = 1'b0;
        vfy_cap      = 1'b0;
        ck_lo_set    = 1'b0;
        ck_lo_clr    = 1'b0;
        fin_ok       = 1'b0;
        fin_pgm_fail = 1'b0;
        fin_ck_fail  = 1'b0;
        case (state)
            ST_IDLE: begin
                if (start) begin
                    nxt       = ST_SUPPLY;
                    addr_clr  = 1'b1;
                    ck_lo_clr = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(SETUP_CYC - 1);
                end
            end
            ST_SUPPLY: begin
                if (tmr_zero) nxt = ST_FETCH;
            end
            ST_FETCH: begin
                nxt = ST_LATCH;
            end
            ST_LATCH: begin
                wr_load = 1'b1;
                pc_clr  = 1'b1;
                if (img_rd_data == ERASED) begin
                    nxt = ST_NEXT;
                end else begin
                    nxt      = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SETUP_CYC - 1);
                end
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    nxt      = ST_PULSE;
                    pc_inc   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(PULSE_CYC - 1);
                end
            end
            ST_PULSE: begin
                if (tmr_zero) begin
                    nxt      = ST_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SETUP_CYC - 1);
                end
            end
            ST_HOLD: begin
                if (tmr_zero) begin
                    nxt      = ST_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SETUP_CYC - 1);
                end
            end
            ST_GAP: begin
                if (tmr_zero) begin
                    nxt      = ST_VERIFY;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(TOE_CYC - 1);
                end
            end
            ST_VERIFY: begin
                if (tmr_zero) begin
                    vfy_cap  = 1'b1;
                    nxt      = ST_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(TDF_CYC - 1);
                end
            end
            ST_RECOVER: begin
                if (tmr_zero) begin
                    if (vfy_ok) begin
                        nxt = ST_NEXT;
                    end else if (pc_limit) begin
                        nxt          = ST_IDLE;
                        fin_pgm_fail = 1'b1;
                    end else begin
                        nxt      = ST_SETUP;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(SETUP_CYC - 1);
                    end
                end
            end
            ST_NEXT: begin
                if (addr_last) begin
                    nxt      = ST_CK_SETTLE;
                    addr_clr = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SETUP_CYC - 1);
                end else begin
                    nxt      = ST_FETCH;
                    addr_adv = 1'b1;
                end
            end
            ST_CK_SETTLE: begin
                if (tmr_zero) nxt = ST_CK_FETCH;
            end
            ST_CK_FETCH: begin
                nxt      = ST_CK_READ;
                tmr_load = 1'b1;
                tmr_val  = TW'(TOE_CYC - 1);
            end
            ST_CK_READ: begin
                if (tmr_zero) begin
                    if (dev_dq_in != img_rd_data) begin
                        nxt         = ST_IDLE;
                        fin_ck_fail = 1'b1;
                    end else begin
                        nxt      = ST_CK_REC;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(TDF_CYC - 1);
                    end
                end
            end
            ST_CK_REC: begin
                if (tmr_zero) begin
                    if (!addr_last) begin
                        nxt      = ST_CK_FETCH;
                        addr_adv = 1'b1;
                    end else if (!ck_lo) begin
                        nxt       = ST_CK_SETTLE;
                        ck_lo_set = 1'b1;
                        addr_clr  = 1'b1;
                        tmr_load  = 1'b1;
                        tmr_val   = TW'(SETUP_CYC - 1);
                    end else begin
                        nxt    = ST_IDLE;
                        fin_ok = 1'b1;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Byte under programming, verify result and check-level select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_byte <= ERASED;
            vfy_ok  <= 1'b0;
            ck_lo   <= 1'b0;
        end else begin
            if (wr_load)   wr_byte <= img_rd_data;
            if (vfy_cap)   vfy_ok  <= (dev_dq_in == wr_byte);
            if (ck_lo_clr) ck_lo   <= 1'b0;
            else if (ck_lo_set) ck_lo <= 1'b1;
        end
    end

    // Run outcome and failure report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done        <= 1'b0;
            fail        <= 1'b0;
            fail_addr   <= '0;
            fail_pulses <= '0;
        end else if (state == ST_IDLE && start) begin
            done        <= 1'b0;
            fail        <= 1'b0;
            fail_addr   <= '0;
            fail_pulses <= '0;
        end else if (fin_ok) begin
            done <= 1'b1;
        end else if (fin_pgm_fail) begin
            fail        <= 1'b1;
            fail_addr   <= addr;
            fail_pulses <= pc_count;
        end else if (fin_ck_fail) begin
            fail        <= 1'b1;
            fail_addr   <= addr;
            fail_pulses <= '0;
        end
    end

    // Supply level decode from the phase of the run.
    always_comb begin
        case (state)
            ST_IDLE:                                vcc_sel = VCC_READ;
            ST_CK_SETTLE, ST_CK_FETCH,
            ST_CK_READ, ST_CK_REC:                  vcc_sel = ck_lo ? VCC_CHK_LO : VCC_CHK_HI;
            default:                                vcc_sel = VCC_PROG;
        endcase
    end

    assign busy        = (state != ST_IDLE);
    assign sup_prog    = (state != ST_IDLE);
    assign dev_e_n     = (state != ST_PULSE);
    assign dev_g_n     = !(state == ST_VERIFY || state == ST_CK_READ);
    assign dev_dq_oe   = (state == ST_SETUP) || (state == ST_PULSE) || (state == ST_HOLD);
    assign dev_dq_out  = wr_byte;
    assign dev_addr    = addr;
    assign img_rd_addr = addr;

    // R4: the data driver and the device output are never on together.
    p_no_contention_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dev_dq_oe |-> dev_g_n);

    // R4: chip enable and output enable are never low together.
    p_e_g_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_e_n |-> dev_g_n);

    // R2: a pulse only happens with programming supplies selected.
    p_pulse_supply_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_e_n |-> (sup_prog && vcc_sel == VCC_PROG));

    // R2: address and data do not move on the edge where the pulse starts.
    p_e_fall_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_e_n) |-> ($stable(dev_addr) && $stable(dev_dq_out)));

    // R6: a programming-phase fail reports the limit; a check fail reports 0.
    p_fail_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> (fail_pulses == '0 || fail_pulses == PCW'(MAX_PULSES)));

    // R9: done and fail are exclusive.
    p_done_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    // R9: idle pins whenever no run is active.
    p_idle_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dev_e_n && dev_g_n && !dev_dq_oe && !sup_prog));

endmodule

// File: tb/sim_eprom_burn_seq.sv
// Bench sim_eprom_burn_seq
// Behavioural device model plus per-clock protocol monitor for the sequencer.
module sim_eprom_burn_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 3;
    localparam int DW         = 8;
    localparam int NB         = 1 << AW;
    localparam int MHZ        = 1;
    localparam int MAXP       = 25;
    localparam int PCW        = $clog2(MAXP + 1);
    localparam int PULSE_CYC  = 100;
    localparam int SETUP_CYC  = 2;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           start;
    logic           busy, done, fail;
    logic [AW-1:0]  fail_addr;
    logic [PCW-1:0] fail_pulses;
    logic [AW-1:0]  img_rd_addr;
    logic [DW-1:0]  img_rd_data;
    logic [AW-1:0]  dev_addr;
    logic [DW-1:0]  dev_dq_out;
    logic           dev_dq_oe;
    logic [DW-1:0]  dev_dq_in;
    logic           dev_e_n, dev_g_n, sup_prog;
    logic [1:0]     vcc_sel;

    logic [DW-1:0] img [NB];
    logic [DW-1:0] mem [NB];
    int need [NB];
    int pulses [NB];
    int weak_hi, weak_lo, rd_hi, rd_lo;
    int n_tests = 0;
    int n_failed = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    eprom_burn_seq #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_MHZ(MHZ), .MAX_PULSES(MAXP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .fail(fail), .fail_addr(fail_addr), .fail_pulses(fail_pulses),
        .img_rd_addr(img_rd_addr), .img_rd_data(img_rd_data),
        .dev_addr(dev_addr), .dev_dq_out(dev_dq_out), .dev_dq_oe(dev_dq_oe),
        .dev_dq_in(dev_dq_in), .dev_e_n(dev_e_n), .dev_g_n(dev_g_n),
        .sup_prog(sup_prog), .vcc_sel(vcc_sel)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_failed++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Image buffer: synchronous read, one cycle of latency.
    always @(posedge clk) img_rd_data <= img[img_rd_addr];

    // Protocol monitor and device model, evaluated once per clock.
    logic [AW-1:0] p_addr;
    logic [DW-1:0] p_dout;
    logic p_oe, p_sup, p_en, p_gn;
    logic [1:0] p_vcc;
    int stab = 0;
    int elow = 0;
    int since_rise = 0;
    bit seen_pulse = 0;

    initial dev_dq_in = 8'hC3;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_addr = dev_addr; p_dout = dev_dq_out; p_oe = dev_dq_oe;
            p_sup = sup_prog; p_vcc = vcc_sel; p_en = 1'b1; p_gn = 1'b1;
            stab = 0; elow = 0; since_rise = 0; seen_pulse = 0;
            dev_dq_in = 8'hC3;
        end else begin
            if (dev_addr != p_addr || dev_dq_out != p_dout || dev_dq_oe != p_oe ||
                sup_prog != p_sup || vcc_sel != p_vcc)
                stab = 0;
            else
                stab++;
            if (p_en && !dev_e_n) begin
                chk(stab >= SETUP_CYC, "R2 setup before pulse", stab, SETUP_CYC);
                chk(sup_prog && vcc_sel == 2'b01, "R2 supplies at pulse", {sup_prog, vcc_sel}, 3'b101);
            end
            if (!dev_e_n) elow++;
            if (!p_en && dev_e_n) begin
                chk(elow == PULSE_CYC, "R3 pulse width", elow, PULSE_CYC);
                elow = 0;
                since_rise = 0;
                seen_pulse = 1;
                if (sup_prog && vcc_sel == 2'b01) begin
                    pulses[int'(dev_addr)]++;
                    if (pulses[int'(dev_addr)] >= need[int'(dev_addr)])
                        mem[int'(dev_addr)] = mem[int'(dev_addr)] & dev_dq_out;
                end
            end else begin
                since_rise++;
            end
            if (seen_pulse && p_oe && (!dev_dq_oe || dev_dq_out != p_dout))
                chk(since_rise >= SETUP_CYC, "R4 data hold", since_rise, SETUP_CYC);
            if (p_gn && !dev_g_n) begin
                chk(dev_e_n && !dev_dq_oe, "R4 verify mode", {dev_e_n, dev_dq_oe}, 2'b10);
                if (vcc_sel == 2'b01)
                    chk(since_rise >= 2 * SETUP_CYC, "R4 gap before G", since_rise, 2 * SETUP_CYC);
                if (vcc_sel == 2'b10) rd_hi++;
                if (vcc_sel == 2'b11) rd_lo++;
            end
            if (dev_dq_oe && !dev_g_n)
                chk(1'b0, "R4 bus contention", 1, 0);
            if (!dev_g_n && dev_e_n) begin
                logic [DW-1:0] v;
                v = mem[int'(dev_addr)];
                if (vcc_sel == 2'b10 && int'(dev_addr) == weak_hi) v = v ^ 8'h01;
                if (vcc_sel == 2'b11 && int'(dev_addr) == weak_lo) v = v ^ 8'h01;
                dev_dq_in = v;
            end else begin
                dev_dq_in = 8'hC3;
            end
            p_addr = dev_addr; p_dout = dev_dq_out; p_oe = dev_dq_oe;
            p_sup = sup_prog; p_vcc = vcc_sel; p_en = dev_e_n; p_gn = dev_g_n;
        end
    end

    task automatic load_base();
        img[0] = 8'h20; img[1] = 8'hFF; img[2] = 8'h8D; img[3] = 8'h00;
        img[4] = 8'hFF; img[5] = 8'h5A; img[6] = 8'hA5; img[7] = 8'h7E;
        need[0] = 1; need[1] = 1; need[2] = 3; need[3] = 25;
        need[4] = 1; need[5] = 2; need[6] = 1; need[7] = 5;
        weak_hi = -1; weak_lo = -1;
    endtask

    task automatic run_burn();
        bit fin;
        for (int i = 0; i < NB; i++) begin
            mem[i] = 8'hFF;
            pulses[i] = 0;
        end
        rd_hi = 0; rd_lo = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        fin = 0;
        for (int k = 0; k < 40000; k++) begin
            @(negedge clk);
            if (done || fail) begin
                fin = 1;
                break;
            end
        end
        chk(fin, "R9 run finishes", fin, 1);
    endtask

    task automatic chk_idle(input string tag);
        chk(dev_e_n && dev_g_n && !dev_dq_oe && !sup_prog && vcc_sel == 2'b00 && !busy,
            tag, {dev_e_n, dev_g_n, dev_dq_oe, sup_prog, vcc_sel, busy}, 7'b1100000);
    endtask

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        load_base();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 reset pins");
        chk(!done && !fail, "R1 reset status", {done, fail}, 0);

        // Run A: full success, one byte needs exactly the limit.
        load_base();
        run_burn();
        chk(done && !fail, "R9 pass outcome", {done, fail}, 2'b10);
        for (int i = 0; i < NB; i++) begin
            int ex;
            ex = (img[i] == 8'hFF) ? 0 : need[i];
            chk(pulses[i] == ex, (img[i] == 8'hFF) ? "R7 erased byte skipped" : "R5 pulses until verify",
                pulses[i], ex);
            chk(mem[i] == img[i], "R5 array content", mem[i], img[i]);
        end
        chk(pulses[3] == MAXP, "R6 limit boundary passes", pulses[3], MAXP);
        chk(rd_hi == NB && rd_lo == NB, "R8 both check passes", {rd_hi[7:0], rd_lo[7:0]}, {8'(NB), 8'(NB)});
        @(negedge clk);
        chk_idle("R9 idle after pass");

        // Run B: one byte never verifies.
        load_base();
        need[5] = 30;
        run_burn();
        chk(fail && !done, "R6 limit fail", {done, fail}, 2'b01);
        chk(fail_addr == 3'd5, "R6 fail address", fail_addr, 5);
        chk(fail_pulses == PCW'(MAXP), "R6 fail pulse count", fail_pulses, MAXP);
        chk(pulses[5] == MAXP, "R6 pulses applied", pulses[5], MAXP);
        chk(pulses[6] == 0 && pulses[7] == 0, "R6 later bytes untouched", pulses[6] + pulses[7], 0);
        chk(rd_hi == 0, "R8 no check after program fail", rd_hi, 0);
        chk_idle("R9 idle after fail");

        // Run C: weak cell only at the lower check level.
        load_base();
        weak_lo = 6;
        run_burn();
        chk(fail && fail_addr == 3'd6 && fail_pulses == 0, "R8 lower check fail",
            {fail, fail_addr, fail_pulses}, {1'b1, 3'd6, 5'd0});
        chk(rd_hi == NB && rd_lo == 7, "R8 upper pass then lower", {rd_hi[7:0], rd_lo[7:0]}, {8'(NB), 8'd7});

        // Run D: weak cell at the upper check level.
        load_base();
        weak_hi = 2;
        run_burn();
        chk(fail && fail_addr == 3'd2 && fail_pulses == 0, "R8 upper check fail",
            {fail, fail_addr, fail_pulses}, {1'b1, 3'd2, 5'd0});
        chk(rd_hi == 3 && rd_lo == 0, "R8 stop at first mismatch", {rd_hi[7:0], rd_lo[7:0]}, {8'd3, 8'd0});

        // Run E: all-erased image gets no pulse at all.
        load_base();
        for (int i = 0; i < NB; i++) img[i] = 8'hFF;
        run_burn();
        begin
            int tot;
            tot = 0;
            for (int i = 0; i < NB; i++) tot += pulses[i];
            chk(tot == 0, "R7 erased image no pulses", tot, 0);
        end
        chk(done && !fail, "R9 erased image pass", {done, fail}, 2'b10);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_failed);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_failed++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_failed);
        $finish;
    end

endmodule